// File: doc/BRIEF.md
# Length-Prefixed Transmit Frame FIFO

This block collects an outgoing Ethernet frame that a host writes one 32-bit word at a time into a single data register. The words are held in a 2048-byte buffer, least significant byte first. The first word written into an empty buffer is a header: its low 16 bits give the payload length, which does not count the 14-byte Ethernet header. Frame bytes start at buffer byte offset 2.

The block compares the stored byte count with the header length and with a programmable word threshold. From these it decides when a whole frame is present and sends it on its own. The host can also force a send at any time. The frame then leaves on a byte stream with valid, ready and last. Short frames can be zero-padded to 60 bytes on the way out.

Two status bits report that a frame has left (transmit-empty) and that a header carried an illegal length (transmit-error). Host writes are stalled while a frame is streaming out.

Top module: `tx_frame_fifo`

## Requirements
- R1: After reset, `wr_ready` is 1, `out_valid` is 0, both status bits are 0, the buffer is empty, pad and auto-CRC are off and the threshold is 0x3F.
- R2: A data write (`wr_sel`=0) into an empty buffer whose bits 15:0 exceed 2032 sets `st_txerr` and is discarded; the buffer stays empty.
- R3: Each accepted data write stores four bytes, bits 7:0 first. A sent frame streams the buffer bytes from offset 2 upward, one per accepted `out_ready` cycle. `out_data` holds steady while `out_ready` is low.
- R4: A data write that finds fewer than 4 free bytes in the 2048-byte buffer stores nothing.
- R5: The frame counts as complete once the stored byte count is at least length+16, or length+20 when auto-CRC (`wr_sel`=1, bit 1) is off. This figure is capped at 2048.
- R6: After a data write, sending starts on its own only if the threshold (`wr_sel`=2, bits 5:0) is below 0x3F, the stored count is at least 4*(threshold*8+1), and the frame is complete. With threshold 0x3F nothing is sent on its own.
- R7: Writing `wr_sel`=3 with bit 0 set to a non-empty buffer sends its contents, using the latched header length.
- R8: With pad enable (`wr_sel`=1, bit 0) set and length+14 below 60, the frame is sent as 60 bytes, and every byte from index length+14 onward is zero.
- R9: The sent length is length+14 (or 60 when padded), truncated to 2046 bytes; `out_last` marks the final byte.
- R10: When the last byte is accepted the buffer empties and `st_txempty` is set. `wr_ready` is 0 from the start of a send until that cycle.
- R11: An acknowledge write (`wr_sel`=4) clears `st_txempty` when bit 0 is set. It clears `st_txerr` and empties the buffer when bit 1 is set.
- R12: A transmit request to an empty buffer produces no output bytes and only sets `st_txempty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, taken when `wr_ready` is 1 |
| wr_sel | input | 3 | Register select: 0 data, 1 control, 2 threshold, 3 transmit request, 4 acknowledge |
| wr_data | input | 32 | Write value |
| wr_ready | output | 1 | Block accepts writes (low while a frame streams) |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Final byte of the frame |
| out_ready | input | 1 | Downstream accepts the byte |
| st_txempty | output | 1 | Transmit-empty status |
| st_txerr | output | 1 | Transmit-error status |

## Verification
A data write or transmit request accepted on a rising edge starts the send on that same edge. The first byte is therefore valid in the cycle right after the write. Status bits change on the edge that takes the write or the final byte, and the buffer empties on that edge as well. The bench model applies the same inputs at every rising edge and compares `wr_ready`, the stream and both status bits at the following falling edge. All of these results are due exactly one edge after their cause, so the comparison needs no tolerance window.

// File: rtl/tfq_pkg.sv
// Package: shared encodings for the transmit frame FIFO.
// Assumes: wr_sel carries one of the select codes below; other codes do nothing.
package tfq_pkg;

    typedef enum logic [2:0] {
        SEL_DATA  = 3'd0,
        SEL_CTRL  = 3'd1,
        SEL_THR   = 3'd2,
        SEL_TXREQ = 3'd3,
        SEL_ACK   = 3'd4
    } tfq_sel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tfq_state_e;

    localparam logic [5:0] THR_OFF = 6'h3F;

endpackage

// File: rtl/tfq_store.sv
// Module: word-wide frame buffer with a byte fill count and a byte read port.
// Assumes: DEPTH_BYTES is a power of two and a multiple of 4; the caller never
// pushes and clears in the same cycle.
module tfq_store #(
    parameter int DEPTH_BYTES = 2048,
    localparam int WORDS = DEPTH_BYTES / 4,
    localparam int AW    = $clog2(WORDS),
    localparam int BW    = $clog2(DEPTH_BYTES),
    localparam int CW    = $clog2(DEPTH_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [31:0]   push_data,
    input  logic          clear,
    input  logic [BW-1:0] rd_addr,
    output logic [CW-1:0] fill,
    output logic [CW-1:0] fill_nxt,
    output logic [7:0]    rd_byte
);

    logic [31:0]   mem [WORDS];
    logic          has_room;
    logic          wr_ok;
    logic [AW-1:0] wr_idx;
    logic [31:0]   rd_word;

    // Room check and next fill count
    always_comb begin
        has_room = fill <= CW'(DEPTH_BYTES - 4);
        wr_ok    = push && has_room && !clear;
        wr_idx   = fill[AW+1:2];
        if (clear)
            fill_nxt = '0;
        else if (wr_ok)
            fill_nxt = fill + CW'(4);
        else
            fill_nxt = fill;
    end

    // Fill count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= '0;
        else
            fill <= fill_nxt;
    end

    // Word storage, written at the current fill position
    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[wr_idx] <= push_data;
    end

    // Byte read: pick the lane of the addressed word
    always_comb begin
        rd_word = mem[rd_addr[BW-1:2]];
        rd_byte = rd_word[8*rd_addr[1:0] +: 8];
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH_BYTES)) else $error("fill above depth"); // R4

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != $past(fill)) |-> (fill == '0 || fill == $past(fill) + CW'(4)))
        else $error("fill moved by other than one word"); // R3

endmodule

// File: rtl/tfq_ctrl.sv
// Module: register decode, send decision and output sequencing.
// Assumes: fill/fill_nxt come from tfq_store; a send reads bytes from offset 2
// of the buffer through rd_addr; writes are taken only while idle.
module tfq_ctrl
    import tfq_pkg::*;
#(
    parameter int DEPTH_BYTES = 2048,
    parameter int LEN_W       = 16,
    localparam int BW      = $clog2(DEPTH_BYTES),
    localparam int CW      = $clog2(DEPTH_BYTES + 1),
    localparam int XW      = LEN_W + 2,
    localparam int MAX_LEN = DEPTH_BYTES - 16,
    localparam int MAX_OUT = DEPTH_BYTES - 2,
    localparam int MIN_FRM = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [LEN_W-1:0] wr_low,
    input  logic             out_ready,
    input  logic [CW-1:0]    fill,
    input  logic [CW-1:0]    fill_nxt,
    output logic             push,
    output logic             clear,
    output logic [BW-1:0]    rd_addr,
    output logic             out_valid,
    output logic             out_last,
    output logic             pad_zone,
    output logic             wr_ready,
    output logic             st_txempty,
    output logic             st_txerr
);

    tfq_state_e       state;
    tfq_sel_e         sel;
    logic [BW-1:0]    idx;
    logic [BW-1:0]    last_idx;
    logic [XW-1:0]    body_len;
    logic             pad_act;
    logic [LEN_W-1:0] hdr_len;
    logic             pad_en;
    logic             crc_on;
    logic [5:0]       thr;

    logic             acc, is_data, is_ctrl, is_thr, is_req, is_ack;
    logic             len_bad, thr_hit, auto_go, req_hit, req_go, go, done;
    logic [LEN_W-1:0] hdr_nxt;
    logic [XW-1:0]    need, need_cap, thr_bytes, body, flen0, flen;

    // Decode the write and compute the send decision for this cycle
    always_comb begin
        sel      = tfq_sel_e'(wr_sel);
        acc      = wr_en && (state == ST_IDLE);
        is_data  = acc && (sel == SEL_DATA);
        is_ctrl  = acc && (sel == SEL_CTRL);
        is_thr   = acc && (sel == SEL_THR);
        is_req   = acc && (sel == SEL_TXREQ);
        is_ack   = acc && (sel == SEL_ACK);
        len_bad  = (fill == '0) && (wr_low > LEN_W'(MAX_LEN));
        push     = is_data && !len_bad;
        hdr_nxt  = (push && fill == '0) ? wr_low : hdr_len;
        need     = XW'(hdr_nxt) + (crc_on ? XW'(16) : XW'(20));
        need_cap = (need > XW'(DEPTH_BYTES)) ? XW'(DEPTH_BYTES) : need;
        thr_bytes = XW'({thr, 5'b00000}) + XW'(4);
        thr_hit  = (thr < THR_OFF) && (XW'(fill_nxt) >= thr_bytes);
        auto_go  = push && thr_hit && (XW'(fill_nxt) >= need_cap);
        req_hit  = is_req && wr_low[0];
        req_go   = req_hit && (fill != '0);
        go       = auto_go || req_go;
        body     = XW'(hdr_nxt) + XW'(14);
        flen0    = (pad_en && body < XW'(MIN_FRM)) ? XW'(MIN_FRM) : body;
        flen     = (flen0 > XW'(MAX_OUT)) ? XW'(MAX_OUT) : flen0;
        done     = (state == ST_SEND) && out_ready && (idx == last_idx);
        clear    = done || (is_ack && wr_low[1]);
    end

    // Output stream view of the sequencer
    always_comb begin
        out_valid = (state == ST_SEND);
        out_last  = out_valid && (idx == last_idx);
        pad_zone  = out_valid && pad_act && (XW'(idx) >= body_len);
        rd_addr   = idx + BW'(2);
        wr_ready  = (state == ST_IDLE);
    end

    // Send sequencer: start on a decision, step on each accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            last_idx <= '0;
            body_len <= '0;
            pad_act  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    state    <= ST_SEND;
                    idx      <= '0;
                    last_idx <= BW'(flen - XW'(1));
                    body_len <= body;
                    pad_act  <= pad_en;
                end
                ST_SEND: if (out_ready) begin
                    if (idx == last_idx)
                        state <= ST_IDLE;
                    else
                        idx <= idx + BW'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Configuration registers and latched header length
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_len <= '0;
            pad_en  <= 1'b0;
            crc_on  <= 1'b0;
            thr     <= THR_OFF;
        end else begin
            hdr_len <= hdr_nxt;
            if (is_ctrl) begin
                pad_en <= wr_low[0];
                crc_on <= wr_low[1];
            end
            if (is_thr)
                thr <= wr_low[5:0];
        end
    end

    // Status bits: set by events, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_txempty <= 1'b0;
            st_txerr   <= 1'b0;
        end else begin
            if (done || (req_hit && fill == '0))
                st_txempty <= 1'b1;
            else if (is_ack && wr_low[0])
                st_txempty <= 1'b0;
            if (is_data && len_bad)
                st_txerr <= 1'b1;
            else if (is_ack && wr_low[1])
                st_txerr <= 1'b0;
        end
    end

    AST_BAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && wr_sel == 3'd0 && fill == '0 && wr_low > LEN_W'(MAX_LEN))
        |=> (st_txerr && fill == '0)) else $error("bad length accepted"); // R2

    AST_THR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ready && wr_sel == 3'd0 && thr == THR_OFF) |=> !out_valid)
        else $error("auto send with threshold off"); // R6

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (idx <= BW'(MAX_OUT - 1))) else $error("read past cap"); // R9

    AST_EMPTY_AFTER_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (fill == '0 && st_txempty && wr_ready))
        else $error("buffer not emptied after send"); // R10

endmodule

// File: rtl/tx_frame_fifo.sv
// Module: top of the length-prefixed transmit frame FIFO.
// Assumes: one register write per cycle through wr_en/wr_sel/wr_data, stalled
// by wr_ready; the byte stream follows valid/ready rules.
module tx_frame_fifo
    import tfq_pkg::*;
#(
    parameter int DEPTH_BYTES = 2048,
    parameter int LEN_W       = 16,
    localparam int BW = $clog2(DEPTH_BYTES),
    localparam int CW = $clog2(DEPTH_BYTES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [31:0] wr_data,
    output logic        wr_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    input  logic        out_ready,
    output logic        st_txempty,
    output logic        st_txerr
);

    logic          push;
    logic          clear;
    logic [BW-1:0] rd_addr;
    logic [CW-1:0] fill;
    logic [CW-1:0] fill_nxt;
    logic [7:0]    rd_byte;
    logic          pad_zone;

    tfq_store #(.DEPTH_BYTES(DEPTH_BYTES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (wr_data),
        .clear     (clear),
        .rd_addr   (rd_addr),
        .fill      (fill),
        .fill_nxt  (fill_nxt),
        .rd_byte   (rd_byte)
    );

    tfq_ctrl #(.DEPTH_BYTES(DEPTH_BYTES), .LEN_W(LEN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_low     (wr_data[LEN_W-1:0]),
        .out_ready  (out_ready),
        .fill       (fill),
        .fill_nxt   (fill_nxt),
        .push       (push),
        .clear      (clear),
        .rd_addr    (rd_addr),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .pad_zone   (pad_zone),
        .wr_ready   (wr_ready),
        .st_txempty (st_txempty),
        .st_txerr   (st_txerr)
    );

    // Padding bytes are forced to zero instead of being written into the buffer
    always_comb begin
        out_data = pad_zone ? 8'h00 : rd_byte;
    end

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)))
        else $error("stream changed while stalled"); // R3

endmodule

// File: tb/tx_frame_fifo_tb.sv
module tx_frame_fifo_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_last;
    logic        out_ready = 1'b1;
    logic        st_txempty;
    logic        st_txerr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int frames_done = 0;
    int rx_q[$];

    // reference model state
    int m_mem [DEPTH];
    int m_cnt, m_hdr, m_pad, m_crc, m_thr, m_txe, m_txerr;
    int m_send, m_idx, m_len, m_body, m_padact;

    tx_frame_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_ready(wr_ready), .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .st_txempty(st_txempty), .st_txerr(st_txerr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model, advanced at every rising edge
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_hdr = 0; m_pad = 0; m_crc = 0; m_thr = 63;
            m_txe = 0; m_txerr = 0; m_send = 0; m_idx = 0; m_len = 0; m_body = 0; m_padact = 0;
        end else if (m_send != 0) begin
            if (out_ready) begin
                if (m_idx == m_len - 1) begin
                    m_send = 0; m_cnt = 0; m_txe = 1;
                end else m_idx++;
            end
        end else if (wr_en) begin
            int go;
            go = 0;
            case (wr_sel)
                3'd0: begin
                    if (m_cnt == 0 && int'(wr_data[15:0]) > 2032) m_txerr = 1;
                    else begin
                        int need;
                        if (m_cnt + 4 <= DEPTH) begin
                            for (int b = 0; b < 4; b++) m_mem[m_cnt + b] = int'(wr_data[8*b +: 8]);
                            if (m_cnt == 0) m_hdr = int'(wr_data[15:0]);
                            m_cnt += 4;
                        end
                        need = m_hdr + (m_crc != 0 ? 16 : 20);
                        if (need > DEPTH) need = DEPTH;
                        if (m_thr < 63 && m_cnt >= 4 * (m_thr * 8 + 1) && m_cnt >= need) go = 1;
                    end
                end
                3'd1: begin m_pad = int'(wr_data[0]); m_crc = int'(wr_data[1]); end
                3'd2: m_thr = int'(wr_data[5:0]);
                3'd3: if (wr_data[0]) begin
                    if (m_cnt == 0) m_txe = 1; else go = 1;
                end
                3'd4: begin
                    if (wr_data[0]) m_txe = 0;
                    if (wr_data[1]) begin m_txerr = 0; m_cnt = 0; end
                end
                default: ;
            endcase
            if (go != 0) begin
                m_body = m_hdr + 14;
                m_len = m_body;
                if (m_pad != 0 && m_len < 60) m_len = 60;
                if (m_len > DEPTH - 2) m_len = DEPTH - 2;
                m_padact = m_pad; m_idx = 0; m_send = 1;
            end
        end
    end

    // Ready pattern, changed away from both edges
    always @(posedge clk) begin
        #2;
        out_ready <= (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    end

    // Compare against the model every cycle and collect the frame bytes
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R10 wr_ready", int'(wr_ready), (m_send != 0) ? 0 : 1);
            chk("R3 out_valid", int'(out_valid), m_send);
            chk("R10 st_txempty", int'(st_txempty), m_txe);
            chk("R2 st_txerr", int'(st_txerr), m_txerr);
            if (m_send != 0 && out_valid) begin
                int e;
                e = (m_padact != 0 && m_idx >= m_body) ? 0 : m_mem[m_idx + 2];
                chk("R3 out_data", int'(out_data), e);
                chk("R9 out_last", int'(out_last), (m_idx == m_len - 1) ? 1 : 0);
            end
            if (out_valid && out_ready) begin
                rx_q.push_back(int'(out_data));
                if (out_last) frames_done++;
            end
        end
    end

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Writes a frame header and the following words; frame byte j = seed+j
    task automatic put_frame(input int len, input int nwords, input int seed);
        for (int k = 0; k < nwords; k++) begin
            logic [31:0] w;
            for (int b = 0; b < 4; b++) begin
                int pos;
                pos = 4 * k + b;
                if (pos < 2) w[8*b +: 8] = 8'(len >> (8 * pos));
                else w[8*b +: 8] = 8'(seed + pos - 2);
            end
            wr(3'd0, w);
        end
    endtask

    task automatic wait_frame(input int fd0);
        while (frames_done == fd0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int fd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 wr_ready", int'(wr_ready), 1);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 status", int'({st_txempty, st_txerr}), 0);

        // R6: default threshold 0x3F never sends on its own
        wr(3'd1, 32'h2);
        put_frame(0, 5, 8'h10);
        repeat (2) @(negedge clk);
        chk("R6 no auto send at reset threshold", int'(out_valid), 0);
        wr(3'd4, 32'h2);

        // R5: complete at length+16 with auto-CRC on, threshold 0
        wr(3'd2, 32'h0);
        rx_q.delete(); fd = frames_done;
        put_frame(20, 8, 8'h40);
        @(negedge clk);
        chk("R5 not complete at length+12", int'(out_valid), 0);
        put_frame(20, 0, 0);
        wr(3'd0, 32'h43424140 + 32'h1c1c1c1c);
        wait_frame(fd);
        chk("R9 frame length", rx_q.size(), 34);
        chk("R3 first byte lsb first", rx_q[0], 8'h40);
        chk("R10 txempty after send", int'(st_txempty), 1);
        wr(3'd4, 32'h1);
        chk("R11 ack clears txempty", int'(st_txempty), 0);

        // R5: auto-CRC off needs 4 more bytes; stalled output
        rdy_mode = 1;
        wr(3'd1, 32'h0);
        rx_q.delete(); fd = frames_done;
        put_frame(20, 9, 8'h60);
        @(negedge clk);
        chk("R5 crc off waits for length+20", int'(out_valid), 0);
        wr(3'd0, 32'h77665544);
        wait_frame(fd);
        chk("R5 crc off frame length", rx_q.size(), 34);

        // R6: threshold 2 needs 68 bytes although the frame completes earlier
        rdy_mode = 0;
        wr(3'd1, 32'h2);
        wr(3'd2, 32'h2);
        rx_q.delete(); fd = frames_done;
        put_frame(10, 16, 8'h80);
        @(negedge clk);
        chk("R6 below threshold count", int'(out_valid), 0);
        wr(3'd0, 32'h01020304);
        wait_frame(fd);
        chk("R6 threshold frame length", rx_q.size(), 24);
        chk("R3 byte 5", rx_q[5], 8'h85);

        // R8: padding to 60 bytes with zeros
        wr(3'd1, 32'h3);
        wr(3'd2, 32'h0);
        rx_q.delete(); fd = frames_done;
        put_frame(10, 7, 8'hA0);
        wait_frame(fd);
        chk("R8 padded length", rx_q.size(), 60);
        chk("R8 last body byte", rx_q[23], 8'hB7);
        chk("R8 pad byte zero", rx_q[24], 0);
        chk("R8 final pad byte zero", rx_q[59], 0);

        // R2: oversize header rejected, buffer stays empty
        wr(3'd1, 32'h2);
        wr(3'd0, 32'h0000_07F1);
        @(negedge clk);
        chk("R2 txerr set", int'(st_txerr), 1);
        rx_q.delete(); fd = frames_done;
        put_frame(20, 9, 8'hC0);
        wait_frame(fd);
        chk("R2 next frame intact", rx_q.size(), 34);
        chk("R2 next frame first byte", rx_q[0], 8'hC0);

        // R11: ack of txerr empties a partial frame; R12 request on empty
        wr(3'd2, 32'h3F);
        wr(3'd4, 32'h1);
        put_frame(20, 3, 8'h11);
        wr(3'd4, 32'h2);
        chk("R11 txerr cleared", int'(st_txerr), 0);
        rx_q.delete();
        wr(3'd3, 32'h1);
        repeat (3) @(negedge clk);
        chk("R12 no bytes from empty request", rx_q.size(), 0);
        chk("R12 txempty set", int'(st_txempty), 1);
        wr(3'd4, 32'h1);

        // R7: forced send of a partial frame
        rx_q.delete(); fd = frames_done;
        put_frame(20, 4, 8'hD0);
        wr(3'd3, 32'h1);
        wait_frame(fd);
        chk("R7 forced frame length", rx_q.size(), 34);
        chk("R7 forced first byte", rx_q[0], 8'hD0);

        // R4, R9: full buffer drops extra word, output truncated to 2046
        wr(3'd1, 32'h0);
        rx_q.delete(); fd = frames_done;
        put_frame(2032, 512, 8'h05);
        wr(3'd0, 32'hEEEE_EEEE);
        wr(3'd3, 32'h1);
        wait_frame(fd);
        chk("R9 truncated length", rx_q.size(), 2046);
        chk("R4 extra word dropped", rx_q[2045], 8'((8'h05 + 2045) & 8'hFF));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule